// File: doc/BRIEF.md
# Multiplexed Bus Register Interface

This block is the host-facing side of a combined scratch-RAM, parallel-port and timer peripheral that sits on a multiplexed 8-bit address/data bus. The host first places an address on the shared bus together with a chip select and an I/O-versus-memory qualifier, and pulses an address strobe. On the falling edge of that strobe the block captures all three. The host then runs a read or a write, and the block steers it either to an internal byte store or to one of six I/O registers.

The I/O side holds the command byte and drives configuration outputs from it: port drive directions, the port C line mode, interrupt enables and a timer command strobe. It also holds the output latches of the three ports and the timer count-length register. The block collects handshake status and a terminal-count pulse from the port and timer logic, and builds a status byte from them. The command register and the status byte share one address. A read of that address clears the sticky timer flag. The tri-state bus is modelled as separate input and output buses plus an output enable. All logic runs on one clock with a synchronous active-high reset. Bus control levels are sampled on that clock.

Top module: `mbus_regif`

## Requirements
- R1: While `rst` is high, at the next clock edge the command register (every configuration output), the port output latches, the timer length and mode, the timer flag, `bus_oe` and `tmr_cmd_vld` all go to zero.
- R2: The address byte, `sel_n` and `io_space` are captured only at the clock edge where `addr_strobe` is first sampled low after being sampled high. Later changes of these inputs do not retarget the access in progress.
- R3: When the captured `sel_n` is 1, no write changes any register or store location, and `bus_oe` stays 0 during reads.
- R4: With captured `io_space` = 0, an access targets the byte store at index `addr[RAM_AW-1:0]`, so addresses that differ only above bit RAM_AW-1 alias. Read data appears on `bus_out` with `bus_oe` = 1 in the cycle after `read_n` is first sampled low.
- R5: With captured `io_space` = 1, the register is chosen by `addr[2:0]`: 000 command/status, 001 port A, 010 port B, 011 port C, 100 timer low byte, 101 timer high byte. Bits 7:3 are ignored. Codes 110 and 111 select nothing: reads keep `bus_oe` at 0 and writes change nothing.
- R6: Command byte fields: bit 0 drives port A out, bit 1 drives port B out, bits 3:2 set the port C mode, bit 4 enables port A interrupts, bit 5 enables port B interrupts, and bits 7:6 form the timer command.
- R7: `pc_out_mask` follows the port C mode: 00 gives 0x00, 11 gives 0x3F, 01 gives 0x38 (lines 5:3 outputs), and 10 gives 0x00 (all lines used for handshake).
- R8: The status byte reads {0, timer flag, B int enable, B buffer full, B interrupt, A int enable, A buffer full, A interrupt} from bit 7 down to bit 0.
- R9: A `tmr_done` pulse sets the timer flag. A status read returns the flag value from its first cycle and holds it for the whole read, then clears the flag. A `tmr_done` pulse in the same cycle that a status read starts wins over the clear.
- R10: Each accepted command write raises `tmr_cmd_vld` for exactly one cycle, with `tmr_cmd` equal to bits 7:6 of the written byte. Other writes raise no strobe.
- R11: A read of port A or port B returns the output latch when that port drives and the pin value otherwise. A read of port C returns the latch on lines set in `pc_out_mask`, the pins on the other lines, and 0 in bits 7:6.
- R12: Writes to the timer low and high bytes set `tmr_len[7:0]`, `tmr_len[13:8]` and `tmr_mode` (high byte bits 7:6). Reads return `tmr_cnt[7:0]` and {`tmr_cnt_mode`, `tmr_cnt[13:8]`}.
- R13: `bus_oe` is 1 only in cycles that follow a cycle in which `read_n` was low, the captured `sel_n` was 0 and a valid target was addressed. It drops in the cycle after `read_n` returns high. `bus_out` is 0 whenever `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe | input | 1 | Address strobe; its falling edge captures the address phase |
| sel_n | input | 1 | Active-low chip select, captured with the address |
| io_space | input | 1 | 1 selects I/O registers, 0 selects the byte store |
| read_n | input | 1 | Active-low read |
| write_n | input | 1 | Active-low write |
| bus_in | input | 8 | Bus value driven by the host (address or write data) |
| bus_out | output | 8 | Read data toward the host |
| bus_oe | output | 1 | Enable for driving bus_out onto the bus |
| port_a_pin | input | 8 | Port A pin levels |
| port_b_pin | input | 8 | Port B pin levels |
| port_c_pin | input | 6 | Port C pin levels |
| port_a_out | output | 8 | Port A output latch |
| port_b_out | output | 8 | Port B output latch |
| port_c_out | output | 6 | Port C output latch |
| port_a_drive | output | 1 | Port A drives its pins |
| port_b_drive | output | 1 | Port B drives its pins |
| pc_mode | output | 2 | Port C line mode |
| pc_out_mask | output | 6 | Port C lines that act as plain outputs |
| a_int_en | output | 1 | Port A interrupt enable |
| b_int_en | output | 1 | Port B interrupt enable |
| a_intr | input | 1 | Port A interrupt request |
| a_bfull | input | 1 | Port A buffer full |
| b_intr | input | 1 | Port B interrupt request |
| b_bfull | input | 1 | Port B buffer full |
| tmr_done | input | 1 | Timer terminal-count pulse |
| tmr_len | output | 14 | Timer count length |
| tmr_mode | output | 2 | Timer output mode |
| tmr_cnt | input | 14 | Present timer count for readback |
| tmr_cnt_mode | input | 2 | Present timer mode for readback |
| tmr_cmd | output | 2 | Timer command code |
| tmr_cmd_vld | output | 1 | One-cycle strobe for tmr_cmd |

## Verification
The bench builds the block with RAM_AW = 5, a 32-byte store. Addresses from 0x20 upward then fold onto the low bytes, so index aliasing can be shown with a handful of writes and reads. The bus width and the I/O decode are fixed by the byte layouts, so only the store depth needs a non-default value. After each address phase the bench flips the select inputs, which exercises the capture on the strobe edge in every access.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam int BUS_W  = 8;
  localparam int PC_W   = 6;
  localparam int TLEN_W = 14;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMD = 3'b000,
    SEL_PA  = 3'b001,
    SEL_PB  = 3'b010,
    SEL_PC  = 3'b011,
    SEL_TLO = 3'b100,
    SEL_THI = 3'b101
  } io_sel_e;

  typedef struct packed {
    logic [1:0] tcmd;
    logic       b_ie;
    logic       a_ie;
    logic [1:0] pc_mode;
    logic       b_drv;
    logic       a_drv;
  } cmd_t;

  function automatic logic sel_valid(input logic [SEL_W-1:0] s);
    return s <= SEL_THI;
  endfunction

  function automatic logic [PC_W-1:0] pc_mask(input logic [1:0] m);
    logic [PC_W-1:0] r;
    case (m)
      2'b11:   r = 6'h3F;
      2'b01:   r = 6'h38;
      default: r = 6'h00;
    endcase
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] make_status(
    input logic tflag, input logic b_ie, input logic b_bf, input logic b_int,
    input logic a_ie, input logic a_bf, input logic a_int);
    return {1'b0, tflag, b_ie, b_bf, b_int, a_ie, a_bf, a_int};
  endfunction

endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic          sel_n,
  input  logic          io_space,
  input  logic [AW-1:0] bus_in,
  output logic [AW-1:0] addr,
  output logic          lat_sel_n,
  output logic          lat_io
);

  logic strobe_q;
  logic fall;

  assign fall = strobe_q & ~strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      addr      <= '0;
      lat_sel_n <= 1'b1;
      lat_io    <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (fall) begin
        addr      <= bus_in;
        lat_sel_n <= sel_n;
        lat_io    <= io_space;
      end
    end
  end

endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/mbus_ctrl_regs.sv
module mbus_ctrl_regs
  import mbus_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               io_we,
  input  logic [SEL_W-1:0]   sel,
  input  logic [BUS_W-1:0]   wdata,
  input  logic               stat_clr,
  input  logic               tmr_done,
  input  logic               a_intr,
  input  logic               a_bfull,
  input  logic               b_intr,
  input  logic               b_bfull,
  output cmd_t               cmd,
  output logic [BUS_W-1:0]   pa_out,
  output logic [BUS_W-1:0]   pb_out,
  output logic [PC_W-1:0]    pc_out,
  output logic [TLEN_W-1:0]  tmr_len,
  output logic [1:0]         tmr_mode,
  output logic               tmr_cmd_vld,
  output logic               tflag,
  output logic [BUS_W-1:0]   status
);

  localparam int HI_W = TLEN_W - BUS_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd         <= '0;
      pa_out      <= '0;
      pb_out      <= '0;
      pc_out      <= '0;
      tmr_len     <= '0;
      tmr_mode    <= '0;
      tmr_cmd_vld <= 1'b0;
    end else begin
      tmr_cmd_vld <= io_we && (sel == SEL_CMD);
      if (io_we) begin
        case (sel)
          SEL_CMD: cmd    <= cmd_t'(wdata);
          SEL_PA:  pa_out <= wdata;
          SEL_PB:  pb_out <= wdata;
          SEL_PC:  pc_out <= wdata[PC_W-1:0];
          SEL_TLO: tmr_len[BUS_W-1:0] <= wdata;
          SEL_THI: begin
            tmr_len[TLEN_W-1:BUS_W] <= wdata[HI_W-1:0];
            tmr_mode                <= wdata[BUS_W-1:BUS_W-2];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           tflag <= 1'b0;
    else if (tmr_done) tflag <= 1'b1;
    else if (stat_clr) tflag <= 1'b0;
  end

  assign status = make_status(tflag, cmd.b_ie, b_bfull, b_intr,
                              cmd.a_ie, a_bfull, a_intr);

endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
  import mbus_pkg::*;
#(
  parameter int RAM_AW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        addr_strobe,
  input  logic        sel_n,
  input  logic        io_space,
  input  logic        read_n,
  input  logic        write_n,
  input  logic [7:0]  bus_in,
  output logic [7:0]  bus_out,
  output logic        bus_oe,
  input  logic [7:0]  port_a_pin,
  input  logic [7:0]  port_b_pin,
  input  logic [5:0]  port_c_pin,
  output logic [7:0]  port_a_out,
  output logic [7:0]  port_b_out,
  output logic [5:0]  port_c_out,
  output logic        port_a_drive,
  output logic        port_b_drive,
  output logic [1:0]  pc_mode,
  output logic [5:0]  pc_out_mask,
  output logic        a_int_en,
  output logic        b_int_en,
  input  logic        a_intr,
  input  logic        a_bfull,
  input  logic        b_intr,
  input  logic        b_bfull,
  input  logic        tmr_done,
  output logic [13:0] tmr_len,
  output logic [1:0]  tmr_mode,
  input  logic [13:0] tmr_cnt,
  input  logic [1:0]  tmr_cnt_mode,
  output logic [1:0]  tmr_cmd,
  output logic        tmr_cmd_vld
);

  localparam int HI_W = TLEN_W - BUS_W;

  // captured address phase
  logic [BUS_W-1:0] lat_addr;
  logic             lat_sel_n;
  logic             lat_io;

  mbus_addr_latch #(.AW(BUS_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .strobe    (addr_strobe),
    .sel_n     (sel_n),
    .io_space  (io_space),
    .bus_in    (bus_in),
    .addr      (lat_addr),
    .lat_sel_n (lat_sel_n),
    .lat_io    (lat_io)
  );

  // read / write start detection
  logic read_q, write_q;
  logic rd_act, rd_start, wr_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      read_q  <= 1'b1;
      write_q <= 1'b1;
    end else begin
      read_q  <= read_n;
      write_q <= write_n;
    end
  end

  assign rd_act   = ~read_n;
  assign rd_start = rd_act & read_q;
  assign wr_start = ~write_n & write_q;

  // target decode
  logic [SEL_W-1:0] reg_sel;
  logic             hit, io_we, ram_we, stat_clr;

  assign reg_sel  = lat_addr[SEL_W-1:0];
  assign hit      = ~lat_sel_n & (~lat_io | sel_valid(reg_sel));
  assign io_we    = wr_start & hit & lat_io;
  assign ram_we   = wr_start & hit & ~lat_io;
  assign stat_clr = rd_start & hit & lat_io & (reg_sel == SEL_CMD);

  // byte store
  logic [BUS_W-1:0] ram_q;

  mbus_ram #(.AW(RAM_AW), .DW(BUS_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (lat_addr[RAM_AW-1:0]),
    .wdata (bus_in),
    .rdata (ram_q)
  );

  // command, latches, status
  cmd_t             cmd;
  logic             tflag;
  logic [BUS_W-1:0] status;

  mbus_ctrl_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .io_we       (io_we),
    .sel         (reg_sel),
    .wdata       (bus_in),
    .stat_clr    (stat_clr),
    .tmr_done    (tmr_done),
    .a_intr      (a_intr),
    .a_bfull     (a_bfull),
    .b_intr      (b_intr),
    .b_bfull     (b_bfull),
    .cmd         (cmd),
    .pa_out      (port_a_out),
    .pb_out      (port_b_out),
    .pc_out      (port_c_out),
    .tmr_len     (tmr_len),
    .tmr_mode    (tmr_mode),
    .tmr_cmd_vld (tmr_cmd_vld),
    .tflag       (tflag),
    .status      (status)
  );

  assign port_a_drive = cmd.a_drv;
  assign port_b_drive = cmd.b_drv;
  assign pc_mode      = cmd.pc_mode;
  assign a_int_en     = cmd.a_ie;
  assign b_int_en     = cmd.b_ie;
  assign tmr_cmd      = cmd.tcmd;
  assign pc_out_mask  = pc_mask(cmd.pc_mode);

  // I/O read selection
  logic [BUS_W-1:0] io_rd;
  logic [PC_W-1:0]  pc_rd;

  assign pc_rd = (port_c_out & pc_out_mask) | (port_c_pin & ~pc_out_mask);

  always_comb begin
    case (reg_sel)
      SEL_CMD: io_rd = status;
      SEL_PA:  io_rd = cmd.a_drv ? port_a_out : port_a_pin;
      SEL_PB:  io_rd = cmd.b_drv ? port_b_out : port_b_pin;
      SEL_PC:  io_rd = {{(BUS_W-PC_W){1'b0}}, pc_rd};
      SEL_TLO: io_rd = tmr_cnt[BUS_W-1:0];
      SEL_THI: io_rd = {tmr_cnt_mode, tmr_cnt[TLEN_W-1:BUS_W]};
      default: io_rd = '0;
    endcase
  end

  // read data hold and output enable
  logic [BUS_W-1:0] io_q;
  logic             src_io;
  logic             oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      io_q   <= '0;
      src_io <= 1'b0;
    end else begin
      oe_q <= rd_act & hit;
      if (rd_start) begin
        io_q   <= io_rd;
        src_io <= lat_io;
      end
    end
  end

  assign bus_oe  = oe_q;
  assign bus_out = oe_q ? (src_io ? io_q : ram_q) : '0;

  if (HI_W + 2 != BUS_W) begin : g_bad_width
    $error("timer high byte layout does not fill the bus");
  end

endmodule

// File: rtl/mbus_regif_chk.sv
module mbus_regif_chk (
  input logic       clk,
  input logic       rst,
  input logic       read_n,
  input logic       write_n,
  input logic       bus_oe,
  input logic       lat_sel_n,
  input logic       tmr_cmd_vld,
  input logic       tflag,
  input logic       tmr_done,
  input logic       port_a_drive,
  input logic       port_b_drive,
  input logic [1:0] pc_mode,
  input logic       a_int_en,
  input logic       b_int_en,
  input logic [7:0] port_a_out,
  input logic [7:0] port_b_out,
  input logic [5:0] port_c_out
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: state after a reset edge
  always @(negedge clk) begin
    if (rst_d) begin
      a_r1_reset_clears: assert (!bus_oe && !tmr_cmd_vld && !tflag &&
                                 !port_a_drive && !port_b_drive && pc_mode == 2'b00 &&
                                 !a_int_en && !b_int_en && port_a_out == 8'h00 &&
                                 port_b_out == 8'h00 && port_c_out == 6'h00);
    end
  end

  a_r13_oe_after_read: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(!read_n));

  a_r3_oe_needs_select: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(!lat_sel_n));

  a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
    tmr_cmd_vld |=> !tmr_cmd_vld);

  a_r10_strobe_from_write: assert property (@(posedge clk) disable iff (rst)
    tmr_cmd_vld |-> $past(!write_n));

  a_r9_flag_set_by_done: assert property (@(posedge clk) disable iff (rst)
    tmr_done |=> tflag);

  a_r9_flag_rise_source: assert property (@(posedge clk) disable iff (rst)
    (tflag && !$past(tflag)) |-> $past(tmr_done));

endmodule

bind mbus_regif mbus_regif_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .read_n       (read_n),
  .write_n      (write_n),
  .bus_oe       (bus_oe),
  .lat_sel_n    (lat_sel_n),
  .tmr_cmd_vld  (tmr_cmd_vld),
  .tflag        (tflag),
  .tmr_done     (tmr_done),
  .port_a_drive (port_a_drive),
  .port_b_drive (port_b_drive),
  .pc_mode      (pc_mode),
  .a_int_en     (a_int_en),
  .b_int_en     (b_int_en),
  .port_a_out   (port_a_out),
  .port_b_out   (port_b_out),
  .port_c_out   (port_c_out)
);

// File: tb/tb_mbus_regif.sv
`timescale 1ns/1ps
module tb_mbus_regif;

  logic        clk = 1'b0;
  logic        rst;
  logic        addr_strobe, sel_n, io_space, read_n, write_n;
  logic [7:0]  bus_in;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [7:0]  port_a_pin, port_b_pin;
  logic [5:0]  port_c_pin;
  logic [7:0]  port_a_out, port_b_out;
  logic [5:0]  port_c_out;
  logic        port_a_drive, port_b_drive;
  logic [1:0]  pc_mode;
  logic [5:0]  pc_out_mask;
  logic        a_int_en, b_int_en;
  logic        a_intr, a_bfull, b_intr, b_bfull;
  logic        tmr_done;
  logic [13:0] tmr_len;
  logic [1:0]  tmr_mode;
  logic [13:0] tmr_cnt;
  logic [1:0]  tmr_cnt_mode;
  logic [1:0]  tmr_cmd;
  logic        tmr_cmd_vld;

  always #2.5 clk = ~clk;

  mbus_regif #(.RAM_AW(5)) dut (
    .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .sel_n(sel_n),
    .io_space(io_space), .read_n(read_n), .write_n(write_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .port_a_pin(port_a_pin), .port_b_pin(port_b_pin), .port_c_pin(port_c_pin),
    .port_a_out(port_a_out), .port_b_out(port_b_out), .port_c_out(port_c_out),
    .port_a_drive(port_a_drive), .port_b_drive(port_b_drive),
    .pc_mode(pc_mode), .pc_out_mask(pc_out_mask),
    .a_int_en(a_int_en), .b_int_en(b_int_en),
    .a_intr(a_intr), .a_bfull(a_bfull), .b_intr(b_intr), .b_bfull(b_bfull),
    .tmr_done(tmr_done), .tmr_len(tmr_len), .tmr_mode(tmr_mode),
    .tmr_cnt(tmr_cnt), .tmr_cnt_mode(tmr_cnt_mode),
    .tmr_cmd(tmr_cmd), .tmr_cmd_vld(tmr_cmd_vld)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  typedef struct {
    logic       oe;
    logic [7:0] d;
    string      tag;
  } exp_item_t;

  exp_item_t exp_q[$];

  int         stb_cnt = 0;
  logic [1:0] stb_last = 2'b00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input bit ai, input bit abf, input bit aie,
                                      input bit bi, input bit bbf, input bit bie,
                                      input bit tf);
    return {1'b0, tf, bie, bbf, bi, aie, abf, ai};
  endfunction

  // monitor: compares bus results against the scoreboard queue
  initial begin
    forever begin
      exp_item_t it;
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        chk(it.tag, {23'b0, bus_oe, bus_out}, {23'b0, it.oe, it.d});
      end
    end
  end

  // strobe counter, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && tmr_cmd_vld) begin
      stb_cnt  <= stb_cnt + 1;
      stb_last <= tmr_cmd;
    end
  end

  task automatic addr_phase(input bit io, input bit sn, input logic [7:0] a);
    @(negedge clk);
    addr_strobe = 1'b1; bus_in = a; io_space = io; sel_n = sn;
    @(negedge clk);
    addr_strobe = 1'b0;
    @(negedge clk);
    io_space = ~io; sel_n = ~sn;   // flipped after capture (R2)
  endtask

  task automatic do_write(input bit io, input bit sn, input logic [7:0] a,
                          input logic [7:0] d);
    addr_phase(io, sn, a);
    bus_in = d; write_n = 1'b0;
    @(negedge clk);
    write_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(input bit io, input bit sn, input logic [7:0] a,
                         input bit eoe, input logic [7:0] ed, input string tag,
                         input bit done_with_rd);
    exp_item_t it;
    addr_phase(io, sn, a);
    bus_in = ~a; read_n = 1'b0;
    if (done_with_rd) tmr_done = 1'b1;
    @(negedge clk);
    tmr_done = 1'b0;
    it.oe = eoe; it.d = eoe ? ed : 8'h00; it.tag = {tag, " first cycle"};
    exp_q.push_back(it);
    @(negedge clk);
    it.tag = {tag, " held cycle"};
    exp_q.push_back(it);
    read_n = 1'b1;
    @(negedge clk);
    it.oe = 1'b0; it.d = 8'h00; it.tag = {tag, " R13 release"};
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); tmr_done = 1'b1;
    @(negedge clk); tmr_done = 1'b0;
  endtask

  task automatic chk_idle_cfg(input string tag);
    chk({tag, " drives"}, {30'b0, port_a_drive, port_b_drive}, 32'd0);
    chk({tag, " pc_mode"}, {30'b0, pc_mode}, 32'd0);
    chk({tag, " int enables"}, {30'b0, a_int_en, b_int_en}, 32'd0);
    chk({tag, " latches"}, {10'b0, port_a_out, port_b_out, port_c_out}, 32'd0);
    chk({tag, " mask"}, {26'b0, pc_out_mask}, 32'd0);
    chk({tag, " timer"}, {16'b0, tmr_mode, tmr_len}, 32'd0);
    chk({tag, " oe/strobe"}, {30'b0, bus_oe, tmr_cmd_vld}, 32'd0);
  endtask

  initial begin
    int s0;
    rst = 1'b1; addr_strobe = 1'b0; sel_n = 1'b1; io_space = 1'b0;
    read_n = 1'b1; write_n = 1'b1; bus_in = 8'h00; tmr_done = 1'b0;
    port_a_pin = 8'hC3; port_b_pin = 8'h96; port_c_pin = 6'h15;
    a_intr = 1'b0; a_bfull = 1'b0; b_intr = 1'b0; b_bfull = 1'b0;
    tmr_cnt = 14'h1ABC; tmr_cnt_mode = 2'b10;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_idle_cfg("R1 reset");

    // R6 / R7 / R10 command layout
    do_write(1'b1, 1'b0, 8'h00, 8'h3D);
    chk("R6 A drive", {31'b0, port_a_drive}, 32'd1);
    chk("R6 B drive", {31'b0, port_b_drive}, 32'd0);
    chk("R6 pc_mode", {30'b0, pc_mode}, 32'd3);
    chk("R6 int enables", {30'b0, a_int_en, b_int_en}, 32'd3);
    chk("R7 mode 11 mask", {26'b0, pc_out_mask}, 32'h3F);
    chk("R10 strobe count", stb_cnt, 32'd1);
    chk("R10 strobe code", {30'b0, stb_last}, 32'd0);
    do_write(1'b1, 1'b0, 8'h00, 8'hC5);
    chk("R7 mode 01 mask", {26'b0, pc_out_mask}, 32'h38);
    chk("R10 strobe count 2", stb_cnt, 32'd2);
    chk("R10 strobe code 11", {30'b0, stb_last}, 32'd3);

    // R5 upper bits ignored, R11 port reads
    do_write(1'b1, 1'b0, 8'hF9, 8'h5A);
    chk("R5 port A via F9", {24'b0, port_a_out}, 32'h5A);
    chk("R10 no strobe on port write", stb_cnt, 32'd2);
    do_read(1'b1, 1'b0, 8'h01, 1'b1, 8'h5A, "R11 port A driven", 1'b0);
    do_write(1'b1, 1'b0, 8'h02, 8'h6B);
    chk("R5 port B latch", {24'b0, port_b_out}, 32'h6B);
    do_read(1'b1, 1'b0, 8'hEA, 1'b1, 8'h96, "R11 port B pins", 1'b0);
    do_write(1'b1, 1'b0, 8'h03, 8'h2A);
    chk("R5 port C latch", {26'b0, port_c_out}, 32'h2A);
    do_read(1'b1, 1'b0, 8'h03, 1'b1, 8'h2D, "R11 port C mixed", 1'b0);
    do_write(1'b1, 1'b0, 8'h00, 8'h08);
    chk("R7 mode 10 mask", {26'b0, pc_out_mask}, 32'h00);
    do_read(1'b1, 1'b0, 8'h01, 1'b1, 8'hC3, "R11 port A pins", 1'b0);
    do_read(1'b1, 1'b0, 8'h03, 1'b1, 8'h15, "R11 port C all pins", 1'b0);
    do_write(1'b1, 1'b0, 8'h00, 8'h00);
    chk("R7 mode 00 mask", {26'b0, pc_out_mask}, 32'h00);

    // R5 unused codes
    s0 = stb_cnt;
    do_read(1'b1, 1'b0, 8'h06, 1'b0, 8'h00, "R5 code 110 read", 1'b0);
    do_write(1'b1, 1'b0, 8'h07, 8'hFF);
    chk("R5 code 111 latches", {10'b0, port_a_out, port_b_out, port_c_out},
        {10'b0, 8'h5A, 8'h6B, 6'h2A});
    chk("R5 code 111 cmd", {24'b0, port_a_drive, port_b_drive, pc_mode, a_int_en, b_int_en, 2'b0}, 32'd0);
    chk("R5 code 111 strobe", stb_cnt, s0);

    // R12 timer registers
    do_write(1'b1, 1'b0, 8'h04, 8'h34);
    do_write(1'b1, 1'b0, 8'h05, 8'hC7);
    chk("R12 length", {18'b0, tmr_len}, 32'h0734);
    chk("R12 mode", {30'b0, tmr_mode}, 32'd3);
    do_read(1'b1, 1'b0, 8'h04, 1'b1, 8'hBC, "R12 count low", 1'b0);
    do_read(1'b1, 1'b0, 8'h05, 1'b1, 8'h9A, "R12 count high", 1'b0);

    // R4 store, aliasing, R2 capture
    do_write(1'b0, 1'b0, 8'h03, 8'hA5);
    do_write(1'b0, 1'b0, 8'h1F, 8'h3C);
    do_write(1'b0, 1'b0, 8'h45, 8'h77);
    do_read(1'b0, 1'b0, 8'h03, 1'b1, 8'hA5, "R4 store 03 R2", 1'b0);
    do_read(1'b0, 1'b0, 8'h1F, 1'b1, 8'h3C, "R4 store 1F", 1'b0);
    do_read(1'b0, 1'b0, 8'h05, 1'b1, 8'h77, "R4 alias 45->05", 1'b0);
    do_read(1'b0, 1'b0, 8'h25, 1'b1, 8'h77, "R4 alias 25", 1'b0);

    // R3 deselected accesses
    s0 = stb_cnt;
    do_write(1'b0, 1'b1, 8'h03, 8'hEE);
    do_read(1'b0, 1'b0, 8'h03, 1'b1, 8'hA5, "R3 store kept", 1'b0);
    do_read(1'b0, 1'b1, 8'h03, 1'b0, 8'h00, "R3 deselected read", 1'b0);
    do_write(1'b1, 1'b1, 8'h00, 8'hFF);
    chk("R3 cmd kept", {24'b0, port_a_drive, port_b_drive, pc_mode, a_int_en, b_int_en, 2'b0}, 32'd0);
    chk("R3 no strobe", stb_cnt, s0);

    // R8 status layout
    a_intr = 1'b1; a_bfull = 1'b0; b_intr = 1'b0; b_bfull = 1'b1;
    do_write(1'b1, 1'b0, 8'h00, 8'h10);
    do_read(1'b1, 1'b0, 8'h00, 1'b1, stat(1, 0, 1, 0, 1, 0, 0), "R8 status 1", 1'b0);
    a_intr = 1'b0; a_bfull = 1'b1; b_intr = 1'b1; b_bfull = 1'b0;
    do_write(1'b1, 1'b0, 8'h00, 8'h20);
    do_read(1'b1, 1'b0, 8'hF8, 1'b1, stat(0, 1, 0, 1, 0, 1, 0), "R8 status 2", 1'b0);

    // R9 timer flag
    pulse_done();
    do_read(1'b1, 1'b0, 8'h00, 1'b1, stat(0, 1, 0, 1, 0, 1, 1), "R9 flag set", 1'b0);
    do_read(1'b1, 1'b0, 8'h00, 1'b1, stat(0, 1, 0, 1, 0, 1, 0), "R9 flag cleared", 1'b0);
    do_read(1'b1, 1'b0, 8'h00, 1'b1, stat(0, 1, 0, 1, 0, 1, 0), "R9 done with read", 1'b1);
    do_read(1'b1, 1'b0, 8'h00, 1'b1, stat(0, 1, 0, 1, 0, 1, 1), "R9 set wins", 1'b0);
    do_read(1'b1, 1'b0, 8'h00, 1'b1, stat(0, 1, 0, 1, 0, 1, 0), "R9 cleared again", 1'b0);

    // R1 reset during operation
    do_write(1'b1, 1'b0, 8'h00, 8'h3F);
    pulse_done();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk_idle_cfg("R1 mid-run reset");
    do_read(1'b1, 1'b0, 8'h00, 1'b1, stat(0, 1, 0, 1, 0, 0, 0), "R1 flag cleared", 1'b0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule